// File: doc/BRIEF.md
# Ring Bus Interjection Generator and Detector

This block gives a clock-and-data ring bus a way to break off any transaction in-band, without an extra wire. It has two halves that share one clock domain. The mediator half runs on the node that owns the bus clock. It passes the normal clock and data from the upstream generator through to the ring. When another node keeps the returning clock line high at a time the mediator is driving it low, the mediator takes over the outputs. It holds the clock high and flips the data line a fixed number of times. It then sends two clocked reason bits and returns the ring to pass-through.

The member half runs on every node. It samples the ring clock and data through a short synchronizer chain and counts data transitions that occur while the clock stays high. Once the count reaches a threshold, the node enters its control state, whatever it was doing before. It latches the data value at each of the next two rising clock edges: the first bit is an end-of-message flag and the second is the receiver's acknowledge. It then pulses a valid strobe and falls back to idle. Normal state changes follow bus clock edges. The interjection itself is recognised from data edges alone.

Top module: `ring_interject`

## Requirements
- R1: After reset, med_busy is 0, the mediator passes its inputs through, mbr_state is idle (code 0) and ctrl_valid is 0.
- R2: While med_busy is 0, med_clk_out equals gen_clk_in and med_data_out equals gen_data_in in the same cycle.
- R3: The mediator starts an interjection (med_busy rises) after ring_clk_in has been 1 while gen_clk_in was 0 for HOLD_CYCLES (default 4) consecutive sampled cycles. A run of HOLD_CYCLES-1 such cycles followed by a break starts nothing.
- R4: During the toggle phase med_clk_out stays 1 and med_data_out changes exactly TOGGLES (default 3) times. Each level is held for HALF_TICKS cycles.
- R5: After the toggle phase the mediator produces two bus clock periods, each low then high. med_data_out carries reason_in[0] (latched when the interjection started) through the first period and reason_in[1] through the second. med_busy then falls.
- R6: A member that sees DETECT_EDGES (default 3) data transitions while its bus clock stays high enters the control state (mbr_state code 2). It does so from idle and from busy alike.
- R7: A low bus clock clears the member's transition count. Two transitions, a low clock, then two more transitions do not cause a control state.
- R8: In the control state the member stores the data at the first rising bus clock edge as ctrl_eom and at the second as ctrl_ack. It pulses ctrl_valid for one cycle and returns to idle in the same cycle.
- R9: An idle member moves to busy (code 1) on a falling data edge while its clock is high. Plain clock pulses leave busy unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gen_clk_in | input | 1 | Bus clock the mediator would normally drive |
| gen_data_in | input | 1 | Bus data the mediator would normally drive |
| ring_clk_in | input | 1 | Clock line returning from the ring |
| reason_in | input | 2 | Control bits to send: bit 0 end of message, bit 1 acknowledge |
| med_clk_out | output | 1 | Mediator clock output to the ring |
| med_data_out | output | 1 | Mediator data output to the ring |
| med_busy | output | 1 | High while the mediator generates an interjection |
| mbr_bus_clk | input | 1 | Ring clock seen by the member |
| mbr_bus_data | input | 1 | Ring data seen by the member |
| mbr_state | output | 2 | Member state: 0 idle, 1 busy, 2 control |
| ctrl_valid | output | 1 | One-cycle strobe when both control bits are captured |
| ctrl_eom | output | 1 | Captured end-of-message bit |
| ctrl_ack | output | 1 | Captured acknowledge bit |

## Verification
The bench drives the mediator's outputs straight into the member. A wrong mediator phase or toggle count therefore shows up twice: on the ring pins during the interjection, and a few cycles later as a missing or wrong control strobe. A member count that is not cleared by a low clock produces a false control state within a few cycles of the third split-up edge. A wrong capture edge makes ctrl_eom or ctrl_ack disagree with reason_in at the strobe.

// File: rtl/ring_interject_pkg.sv
package ring_interject_pkg;

   typedef enum logic [1:0] {
      MB_IDLE = 2'd0,
      MB_BUSY = 2'd1,
      MB_CTRL = 2'd2
   } mbr_state_t;

   typedef enum logic [1:0] {
      MD_PASS   = 2'd0,
      MD_TOGGLE = 2'd1,
      MD_CTRL   = 2'd2
   } med_state_t;

endpackage

// File: rtl/rij_mediator.sv
module rij_mediator
   import ring_interject_pkg::*;
#(
   parameter int HOLD_CYCLES = 4,
   parameter int TOGGLES     = 3,
   parameter int HALF_TICKS  = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       gen_clk_in,
   input  logic       gen_data_in,
   input  logic       ring_clk_in,
   input  logic [1:0] reason_in,
   output logic       clk_out,
   output logic       data_out,
   output logic       busy
);

   localparam int HW = $clog2(HOLD_CYCLES + 1);
   localparam int TW = $clog2(HALF_TICKS + 1);
   localparam int GW = $clog2(TOGGLES + 1);

   med_state_t     st_q;
   logic [HW-1:0]  hold_q;
   logic [TW-1:0]  tick_q;
   logic [GW-1:0]  tog_q;
   logic           clk_q, data_q, phase_q, bit_q;
   logic [1:0]     reason_q;

   logic held_req, tick_end;
   assign held_req = ring_clk_in && !gen_clk_in;
   assign tick_end = (tick_q == TW'(HALF_TICKS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= MD_PASS;
         hold_q   <= '0;
         tick_q   <= '0;
         tog_q    <= '0;
         clk_q    <= 1'b1;
         data_q   <= 1'b1;
         phase_q  <= 1'b0;
         bit_q    <= 1'b0;
         reason_q <= 2'b00;
      end else begin
         case (st_q)
            MD_PASS: begin
               if (!held_req) begin
                  hold_q <= '0;
               end else if (hold_q == HW'(HOLD_CYCLES - 1)) begin
                  hold_q   <= '0;
                  st_q     <= MD_TOGGLE;
                  clk_q    <= 1'b1;
                  data_q   <= gen_data_in;
                  tick_q   <= '0;
                  tog_q    <= '0;
                  reason_q <= reason_in;
               end else begin
                  hold_q <= hold_q + 1'b1;
               end
            end
            MD_TOGGLE: begin
               if (!tick_end) begin
                  tick_q <= tick_q + 1'b1;
               end else begin
                  tick_q <= '0;
                  if (tog_q == GW'(TOGGLES)) begin
                     st_q    <= MD_CTRL;
                     clk_q   <= 1'b0;
                     data_q  <= reason_q[0];
                     phase_q <= 1'b0;
                     bit_q   <= 1'b0;
                  end else begin
                     data_q <= ~data_q;
                     tog_q  <= tog_q + 1'b1;
                  end
               end
            end
            MD_CTRL: begin
               if (!tick_end) begin
                  tick_q <= tick_q + 1'b1;
               end else begin
                  tick_q <= '0;
                  if (!phase_q) begin
                     clk_q   <= 1'b1;
                     phase_q <= 1'b1;
                  end else if (!bit_q) begin
                     bit_q   <= 1'b1;
                     phase_q <= 1'b0;
                     clk_q   <= 1'b0;
                     data_q  <= reason_q[1];
                  end else begin
                     st_q <= MD_PASS;
                  end
               end
            end
            default: st_q <= MD_PASS;
         endcase
      end
   end

   assign busy     = (st_q != MD_PASS);
   assign clk_out  = busy ? clk_q  : gen_clk_in;
   assign data_out = busy ? data_q : gen_data_in;

   assert_start_after_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(held_req));

   assert_clk_high_toggle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == MD_TOGGLE && $past(st_q == MD_TOGGLE)) |-> (clk_out && $past(clk_out)));

   assert_end_after_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(clk_out));

endmodule

// File: rtl/rij_member.sv
module rij_member
   import ring_interject_pkg::*;
#(
   parameter int DETECT_EDGES = 3,
   parameter int SYNC_STAGES  = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bus_clk,
   input  logic       bus_data,
   output logic [1:0] state,
   output logic       valid,
   output logic       eom,
   output logic       ack
);

   localparam int CW = $clog2(DETECT_EDGES + 1);

   logic s_clk, s_data, p_clk, p_data;

   generate
      if (SYNC_STAGES == 1) begin : g_sync_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               s_clk  <= 1'b0;
               s_data <= 1'b1;
            end else begin
               s_clk  <= bus_clk;
               s_data <= bus_data;
            end
         end
      end else begin : g_sync_chain
         logic [SYNC_STAGES-1:0] clk_sr, data_sr;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               clk_sr  <= '0;
               data_sr <= '1;
            end else begin
               clk_sr  <= {clk_sr[SYNC_STAGES-2:0], bus_clk};
               data_sr <= {data_sr[SYNC_STAGES-2:0], bus_data};
            end
         end
         assign s_clk  = clk_sr[SYNC_STAGES-1];
         assign s_data = data_sr[SYNC_STAGES-1];
      end
   endgenerate

   mbr_state_t    st_q;
   logic [CW-1:0] cnt_q;
   logic          bit_q, eom_q, ack_q, valid_q;

   logic hi_toggle, rise, detect;
   assign hi_toggle = s_clk && p_clk && (s_data != p_data);
   assign rise      = s_clk && !p_clk;
   assign detect    = hi_toggle && (st_q != MB_CTRL) && (cnt_q == CW'(DETECT_EDGES - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         p_clk   <= 1'b0;
         p_data  <= 1'b1;
         st_q    <= MB_IDLE;
         cnt_q   <= '0;
         bit_q   <= 1'b0;
         eom_q   <= 1'b0;
         ack_q   <= 1'b0;
         valid_q <= 1'b0;
      end else begin
         p_clk   <= s_clk;
         p_data  <= s_data;
         valid_q <= 1'b0;
         if (!s_clk || st_q == MB_CTRL || detect) begin
            cnt_q <= '0;
         end else if (hi_toggle) begin
            cnt_q <= cnt_q + 1'b1;
         end
         if (detect) begin
            st_q  <= MB_CTRL;
            bit_q <= 1'b0;
         end else begin
            case (st_q)
               MB_IDLE: if (s_clk && p_clk && p_data && !s_data) st_q <= MB_BUSY;
               MB_BUSY: st_q <= MB_BUSY;
               MB_CTRL: if (rise) begin
                  if (!bit_q) begin
                     eom_q <= s_data;
                     bit_q <= 1'b1;
                  end else begin
                     ack_q   <= s_data;
                     valid_q <= 1'b1;
                     st_q    <= MB_IDLE;
                  end
               end
               default: st_q <= MB_IDLE;
            endcase
         end
      end
   end

   assign state = st_q;
   assign valid = valid_q;
   assign eom   = eom_q;
   assign ack   = ack_q;

   assert_detect_clk_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == MB_CTRL && $past(st_q != MB_CTRL)) |-> $past(s_clk && p_clk));

   assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      valid |=> !valid);

   assert_valid_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> (st_q == MB_IDLE && $past(st_q == MB_CTRL)));

   assert_count_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!s_clk) |-> (cnt_q == '0));

endmodule

// File: rtl/ring_interject.sv
module ring_interject
   import ring_interject_pkg::*;
#(
   parameter int HOLD_CYCLES  = 4,
   parameter int TOGGLES      = 3,
   parameter int HALF_TICKS   = 2,
   parameter int DETECT_EDGES = 3,
   parameter int SYNC_STAGES  = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       gen_clk_in,
   input  logic       gen_data_in,
   input  logic       ring_clk_in,
   input  logic [1:0] reason_in,
   output logic       med_clk_out,
   output logic       med_data_out,
   output logic       med_busy,
   input  logic       mbr_bus_clk,
   input  logic       mbr_bus_data,
   output logic [1:0] mbr_state,
   output logic       ctrl_valid,
   output logic       ctrl_eom,
   output logic       ctrl_ack
);

   generate
      if (HOLD_CYCLES < 1) begin : g_bad_hold
         $error("HOLD_CYCLES must be at least 1");
      end
      if (HALF_TICKS < 1) begin : g_bad_half
         $error("HALF_TICKS must be at least 1");
      end
      if (DETECT_EDGES < 2) begin : g_bad_detect
         $error("DETECT_EDGES must be at least 2");
      end
      if (TOGGLES < DETECT_EDGES) begin : g_bad_toggles
         $error("TOGGLES must not be below DETECT_EDGES");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
   endgenerate

   rij_mediator #(
      .HOLD_CYCLES (HOLD_CYCLES),
      .TOGGLES     (TOGGLES),
      .HALF_TICKS  (HALF_TICKS)
   ) u_med (
      .clk         (clk),
      .rst_n       (rst_n),
      .gen_clk_in  (gen_clk_in),
      .gen_data_in (gen_data_in),
      .ring_clk_in (ring_clk_in),
      .reason_in   (reason_in),
      .clk_out     (med_clk_out),
      .data_out    (med_data_out),
      .busy        (med_busy)
   );

   rij_member #(
      .DETECT_EDGES (DETECT_EDGES),
      .SYNC_STAGES  (SYNC_STAGES)
   ) u_mbr (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_clk  (mbr_bus_clk),
      .bus_data (mbr_bus_data),
      .state    (mbr_state),
      .valid    (ctrl_valid),
      .eom      (ctrl_eom),
      .ack      (ctrl_ack)
   );

endmodule

// File: tb/ring_interject_test.sv
module ring_interject_test;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       gen_clk_in = 1'b0, gen_data_in = 1'b1, ring_clk_in = 1'b0;
   logic [1:0] reason_in = 2'b00;
   logic       med_clk_out, med_data_out, med_busy;
   logic       loop = 1'b0, drv_clk = 1'b0, drv_data = 1'b1;
   logic       mbr_bus_clk, mbr_bus_data;
   logic [1:0] mbr_state;
   logic       ctrl_valid, ctrl_eom, ctrl_ack;

   int checks = 0;
   int failures = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign mbr_bus_clk  = loop ? med_clk_out  : drv_clk;
   assign mbr_bus_data = loop ? med_data_out : drv_data;

   ring_interject uut (
      .clk(clk), .rst_n(rst_n),
      .gen_clk_in(gen_clk_in), .gen_data_in(gen_data_in),
      .ring_clk_in(ring_clk_in), .reason_in(reason_in),
      .med_clk_out(med_clk_out), .med_data_out(med_data_out), .med_busy(med_busy),
      .mbr_bus_clk(mbr_bus_clk), .mbr_bus_data(mbr_bus_data),
      .mbr_state(mbr_state), .ctrl_valid(ctrl_valid),
      .ctrl_eom(ctrl_eom), .ctrl_ack(ctrl_ack)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic t_reset;
      check(med_busy == 1'b0, "R1 busy", med_busy, 0);
      check(mbr_state == 2'd0, "R1 state", mbr_state, 0);
      check(ctrl_valid == 1'b0, "R1 valid", ctrl_valid, 0);
      check(med_clk_out == gen_clk_in, "R1 pass clk", med_clk_out, gen_clk_in);
   endtask

   task automatic t_pass;
      for (int k = 0; k < 4; k++) begin
         gen_clk_in  = k[0];
         gen_data_in = k[1];
         #1;
         check(med_clk_out == k[0] && med_data_out == k[1], "R2 pass",
               {med_clk_out, med_data_out}, {k[0], k[1]});
         cycles(1);
      end
      gen_clk_in = 1'b0;
      gen_data_in = 1'b1;
      cycles(1);
   endtask

   task automatic t_short_hold;
      ring_clk_in = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(med_busy == 1'b0, "R3 three cycles", med_busy, 0);
      ring_clk_in = 1'b0;
      cycles(3);
      check(med_busy == 1'b0, "R3 after break", med_busy, 0);
   endtask

   task automatic t_interject(input logic [1:0] rsn);
      int  toggles = 0, rises = 0, valids = 0;
      bit  clk_dropped = 0, ctrl_seen = 0;
      logic [1:0] bits = 2'b00;
      logic pc, pd, got_eom = 1'b0, got_ack = 1'b0;
      int  tail = 0;
      loop = 1'b1;
      reason_in = rsn;
      gen_clk_in = 1'b0;
      gen_data_in = 1'b1;
      cycles(6);
      ring_clk_in = 1'b1;
      repeat (4) @(posedge clk);
      @(negedge clk);
      check(med_busy == 1'b1, "R3 four cycles", med_busy, 1);
      ring_clk_in = 1'b0;
      reason_in = ~rsn;
      pc = med_clk_out;
      pd = med_data_out;
      for (int n = 0; n < 120 && tail < 12; n++) begin
         @(negedge clk);
         if (med_busy) begin
            if (med_clk_out && pc && med_data_out != pd) toggles++;
            if (!med_clk_out && toggles < 3) clk_dropped = 1;
            if (med_clk_out && !pc) begin
               if (rises < 2) bits[rises] = med_data_out;
               rises++;
            end
         end else begin
            tail++;
         end
         if (mbr_state == 2'd2) ctrl_seen = 1;
         if (ctrl_valid) begin
            valids++;
            got_eom = ctrl_eom;
            got_ack = ctrl_ack;
            check(mbr_state == 2'd0, "R8 idle at strobe", mbr_state, 0);
         end
         pc = med_clk_out;
         pd = med_data_out;
      end
      check(toggles == 3, "R4 toggles", toggles, 3);
      check(!clk_dropped, "R4 clock held high", clk_dropped, 0);
      check(rises == 2, "R5 two periods", rises, 2);
      check(bits == rsn, "R5 reason bits", bits, rsn);
      check(med_busy == 1'b0, "R5 back to pass", med_busy, 0);
      check(ctrl_seen, "R6 control reached", ctrl_seen, 1);
      check(valids == 1, "R8 one strobe", valids, 1);
      check(got_eom == rsn[0], "R8 eom", got_eom, rsn[0]);
      check(got_ack == rsn[1], "R8 ack", got_ack, rsn[1]);
      loop = 1'b0;
      drv_clk = 1'b0;
      drv_data = 1'b1;
      cycles(6);
   endtask

   task automatic drive(input logic c, input logic d);
      drv_clk = c;
      drv_data = d;
      cycles(4);
   endtask

   task automatic t_member_direct;
      loop = 1'b0;
      drive(1'b0, 1'b1);
      check(mbr_state == 2'd0, "R9 idle start", mbr_state, 0);
      drive(1'b1, 1'b1);
      drive(1'b1, 1'b0);
      check(mbr_state == 2'd1, "R9 to busy", mbr_state, 1);
      drive(1'b1, 1'b1);
      drive(1'b0, 1'b1);
      drive(1'b1, 1'b1);
      drive(1'b1, 1'b0);
      drive(1'b1, 1'b1);
      check(mbr_state == 2'd1, "R7 split edges ignored", mbr_state, 1);
      drive(1'b0, 1'b1);
      drive(1'b1, 1'b1);
      drive(1'b0, 1'b1);
      check(mbr_state == 2'd1, "R9 clock pulses keep busy", mbr_state, 1);
      drive(1'b1, 1'b1);
      drive(1'b1, 1'b0);
      drive(1'b1, 1'b1);
      drive(1'b1, 1'b0);
      check(mbr_state == 2'd2, "R6 control from busy", mbr_state, 2);
      drive(1'b0, 1'b1);
      drive(1'b1, 1'b1);
      check(mbr_state == 2'd2, "R8 waits second bit", mbr_state, 2);
      drv_clk = 1'b0;
      drv_data = 1'b0;
      cycles(4);
      drv_clk = 1'b1;
      begin
         bit seen = 0;
         for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (ctrl_valid) begin
               seen = 1;
               check(ctrl_eom == 1'b1 && ctrl_ack == 1'b0, "R8 direct bits",
                     {ctrl_eom, ctrl_ack}, 2);
            end
         end
         check(seen, "R8 direct strobe", seen, 1);
      end
      check(mbr_state == 2'd0, "R8 back to idle", mbr_state, 0);
   endtask

   initial begin
      cycles(3);
      t_reset;
      rst_n = 1'b1;
      cycles(2);
      t_pass;
      t_short_hold;
      t_interject(2'b01);
      t_interject(2'b10);
      t_interject(2'b11);
      t_member_direct;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 20000);
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule